// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block sits beside a load pipeline and a small store queue. When a load issues, it presents its virtual address, its physical address, a 16-lane byte mask for a 128-bit access, and a mask that marks which store queue entries are older than the load. The block compares the load against every older store on both addresses. For each byte lane it picks the youngest older store that writes that lane. It returns a fast per-lane forward mask in the issue cycle. One cycle later it returns the full forward mask with the forwarded bytes.

The lookup also tells the load pipeline when the load cannot complete. This happens when the chosen store has no data yet, or when an older store has no known address yet. In both cases the block names the store queue entry that caused it. When the virtual-address and physical-address hit vectors disagree, the block raises a flag that asks for a flush.

The store queue is held inside the block as a register array. One write port sets a whole entry: its addresses, its byte mask, its data and two readiness bits.

Top module: `sfw_lookup`

## Requirements
- R1: After reset all stage-two outputs are zero. Every store queue entry is marked as having neither a known address nor written data.
- R2: In the cycle of a valid request, `s1_fwd_mask_fast[L]` is 1 exactly when lane L has a selected store and that store's data is written. A selected store is the youngest older entry whose address is known, whose virtual line matches, and whose mask and the load mask both have bit L set.
- R3: On the rising edge after a valid request, `s2_fwd_mask` takes the lanes of R2. Lane L of `s2_fwd_data` (bits 8L+7..8L) is byte L of the selected store's data, and it is zero in every lane that is not forwarded.
- R4: Age order is circular. The youngest older entry is the set bit i of `ld_older` whose bit (i+1) mod N is clear. Age then falls as the index steps downward with wrap. When `ld_older` is all ones, entry N-1 is the youngest.
- R5: Addresses are compared as 16-byte lines, with bits 3..0 ignored. A store on another line, or one whose mask shares no lane with the load mask, forwards nothing.
- R6: When a selected store's data is not written, `s1_dinv_fast` is 1 in the request cycle. In the next cycle `s2_dinv` is 1 and `s2_dinv_idx` holds the youngest such entry. The index is zero when the flag is low. A store hidden in every lane by a younger store that has data raises nothing.
- R7: When any older entry has an unknown address, `s2_ainv` is 1 in the next cycle. `s2_ainv_idx` holds the youngest such entry, and it is zero when the flag is low.
- R8: Per entry, a hit means older, address known, line match and mask overlap. This is computed once on virtual and once on physical addresses. When the two hit vectors differ, `s2_minv` is 1 in the next cycle.
- R9: Entries whose `ld_older` bit is 0 never forward data and never raise any flag.
- R10: When `ld_valid` is 0, the stage-one outputs are zero in that cycle and all stage-two outputs are zero in the next cycle.
- R11: A write to the store queue changes lookups from the following cycle on. A lookup in the same cycle as a write sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sq_wr_en | input | 1 | Write one store queue entry |
| sq_wr_idx | input | IDX_W | Entry to write |
| sq_wr_va | input | VA_W | Store virtual address |
| sq_wr_pa | input | PA_W | Store physical address |
| sq_wr_mask | input | 16 | Store byte lanes |
| sq_wr_addr_ok | input | 1 | Store address is known |
| sq_wr_data | input | 128 | Store data, byte L in bits 8L+7..8L |
| sq_wr_data_ok | input | 1 | Store data is written |
| ld_valid | input | 1 | Load request present |
| ld_va | input | VA_W | Load virtual address |
| ld_pa | input | PA_W | Load physical address |
| ld_mask | input | 16 | Load byte lanes |
| ld_older | input | N | Entries older than the load |
| s1_fwd_mask_fast | output | 16 | Fast forward lanes, same cycle |
| s1_dinv_fast | output | 1 | Fast data-not-ready indication |
| s2_fwd_mask | output | 16 | Forwarded lanes, next cycle |
| s2_fwd_data | output | 128 | Forwarded bytes, next cycle |
| s2_dinv | output | 1 | Selected store data not ready, replay |
| s2_dinv_idx | output | IDX_W | Entry behind s2_dinv |
| s2_ainv | output | 1 | Older store address unknown, replay |
| s2_ainv_idx | output | IDX_W | Entry behind s2_ainv |
| s2_minv | output | 1 | Virtual and physical hit vectors differ |

## Verification
The stage-one outputs are combinational in the request. The bench drives each request on a falling edge and checks the fast mask and the fast data flag a moment later, in that same low phase. The stage-two mask, data, flags and indices pass through one register. They are checked at the next falling edge, after exactly one rising edge. A store queue write takes effect at the rising edge that follows it, so the bench's model of the queue is updated only after that edge. The same-cycle write test therefore expects the old contents in both stages.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    localparam int LANES   = 16;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = LANES * BYTE_W;
    localparam int LINE_LO = $clog2(LANES);

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] line_data_t;
endpackage

// File: rtl/sfw_entry_array.sv
module sfw_entry_array
    import sfw_pkg::*;
#(
    parameter int N     = 8,
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [VA_W-1:0]            wr_va,
    input  logic [PA_W-1:0]            wr_pa,
    input  lane_mask_t                 wr_mask,
    input  logic                       wr_addr_ok,
    input  line_data_t                 wr_data,
    input  logic                       wr_data_ok,
    output logic [N-1:0]               aok_o,
    output logic [N-1:0]               dok_o,
    output logic [N-1:0][VA_W-1:0]     va_o,
    output logic [N-1:0][PA_W-1:0]     pa_o,
    output logic [N-1:0][LANES-1:0]    mask_o,
    output logic [N-1:0][DATA_W-1:0]   data_o
);
    typedef struct packed {
        logic              aok;
        logic              dok;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
        lane_mask_t        mask;
        line_data_t        data;
    } slot_t;

    slot_t [N-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en && (int'(wr_idx) < N)) begin
            slot_d[wr_idx].aok  = wr_addr_ok;
            slot_d[wr_idx].dok  = wr_data_ok;
            slot_d[wr_idx].va   = wr_va;
            slot_d[wr_idx].pa   = wr_pa;
            slot_d[wr_idx].mask = wr_mask;
            slot_d[wr_idx].data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign aok_o[i]  = slot_q[i].aok;
        assign dok_o[i]  = slot_q[i].dok;
        assign va_o[i]   = slot_q[i].va;
        assign pa_o[i]   = slot_q[i].pa;
        assign mask_o[i] = slot_q[i].mask;
        assign data_o[i] = slot_q[i].data;
    end
endmodule

// File: rtl/sfw_match_vec.sv
module sfw_match_vec
    import sfw_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 40,
    parameter int PA_W = 36
) (
    input  logic [VA_W-1:0]           ld_va,
    input  logic [PA_W-1:0]           ld_pa,
    input  lane_mask_t                ld_mask,
    input  logic [N-1:0]              older,
    input  logic [N-1:0]              aok,
    input  logic [N-1:0][VA_W-1:0]    ent_va,
    input  logic [N-1:0][PA_W-1:0]    ent_pa,
    input  logic [N-1:0][LANES-1:0]   ent_mask,
    output logic [N-1:0]              va_hit,
    output logic [N-1:0]              pa_hit,
    output logic [N-1:0]              addr_unknown
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        logic live, overlap, va_line_eq, pa_line_eq;
        assign live       = older[i] & aok[i];
        assign overlap    = |(ent_mask[i] & ld_mask);
        assign va_line_eq = (ent_va[i][VA_W-1:LINE_LO] == ld_va[VA_W-1:LINE_LO]);
        assign pa_line_eq = (ent_pa[i][PA_W-1:LINE_LO] == ld_pa[PA_W-1:LINE_LO]);
        assign va_hit[i]       = live & overlap & va_line_eq;
        assign pa_hit[i]       = live & overlap & pa_line_eq;
        assign addr_unknown[i] = older[i] & ~aok[i];
    end
endmodule

// File: rtl/sfw_age_pick.sv
module sfw_age_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] youngest,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(youngest) + N - k) % N;
            if (cand[pos]) begin
                hit = 1'b1;
                idx = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/sfw_lookup.sv
module sfw_lookup
    import sfw_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 40,
    parameter int PA_W = 36,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sq_wr_en,
    input  logic [IDX_W-1:0]     sq_wr_idx,
    input  logic [VA_W-1:0]      sq_wr_va,
    input  logic [PA_W-1:0]      sq_wr_pa,
    input  logic [15:0]          sq_wr_mask,
    input  logic                 sq_wr_addr_ok,
    input  logic [127:0]         sq_wr_data,
    input  logic                 sq_wr_data_ok,
    input  logic                 ld_valid,
    input  logic [VA_W-1:0]      ld_va,
    input  logic [PA_W-1:0]      ld_pa,
    input  logic [15:0]          ld_mask,
    input  logic [N-1:0]         ld_older,
    output logic [15:0]          s1_fwd_mask_fast,
    output logic                 s1_dinv_fast,
    output logic [15:0]          s2_fwd_mask,
    output logic [127:0]         s2_fwd_data,
    output logic                 s2_dinv,
    output logic [IDX_W-1:0]     s2_dinv_idx,
    output logic                 s2_ainv,
    output logic [IDX_W-1:0]     s2_ainv_idx,
    output logic                 s2_minv
);
    typedef struct packed {
        lane_mask_t       fwd_mask;
        line_data_t       fwd_data;
        logic             dinv;
        logic [IDX_W-1:0] dinv_idx;
        logic             ainv;
        logic [IDX_W-1:0] ainv_idx;
        logic             minv;
    } stage2_t;

    logic [N-1:0]             aok, dok;
    logic [N-1:0][VA_W-1:0]   ent_va;
    logic [N-1:0][PA_W-1:0]   ent_pa;
    logic [N-1:0][LANES-1:0]  ent_mask;
    logic [N-1:0][DATA_W-1:0] ent_data;

    sfw_entry_array #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sq_wr_en),
        .wr_idx     (sq_wr_idx),
        .wr_va      (sq_wr_va),
        .wr_pa      (sq_wr_pa),
        .wr_mask    (sq_wr_mask),
        .wr_addr_ok (sq_wr_addr_ok),
        .wr_data    (sq_wr_data),
        .wr_data_ok (sq_wr_data_ok),
        .aok_o      (aok),
        .dok_o      (dok),
        .va_o       (ent_va),
        .pa_o       (ent_pa),
        .mask_o     (ent_mask),
        .data_o     (ent_data)
    );

    logic [N-1:0] va_hit, pa_hit, addr_unknown;

    sfw_match_vec #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_match (
        .ld_va        (ld_va),
        .ld_pa        (ld_pa),
        .ld_mask      (ld_mask),
        .older        (ld_older),
        .aok          (aok),
        .ent_va       (ent_va),
        .ent_pa       (ent_pa),
        .ent_mask     (ent_mask),
        .va_hit       (va_hit),
        .pa_hit       (pa_hit),
        .addr_unknown (addr_unknown)
    );

    // Youngest older entry: last set bit of the circular run.
    logic [IDX_W-1:0] youngest;
    always_comb begin
        youngest = IDX_W'(N - 1);
        for (int i = 0; i < N; i++) begin
            if (ld_older[i] && !ld_older[(i + 1) % N]) youngest = IDX_W'(i);
        end
    end

    lane_mask_t                   lane_hit, lane_fwd, lane_wait;
    logic [LANES-1:0][IDX_W-1:0]  lane_sel;
    line_data_t                   lane_bytes;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [N-1:0] cand;
        for (genvar i = 0; i < N; i++) begin : g_cand
            assign cand[i] = va_hit[i] & ent_mask[i][l] & ld_mask[l];
        end
        sfw_age_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
            .cand     (cand),
            .youngest (youngest),
            .hit      (lane_hit[l]),
            .idx      (lane_sel[l])
        );
        assign lane_fwd[l]  = lane_hit[l] &  dok[lane_sel[l]];
        assign lane_wait[l] = lane_hit[l] & ~dok[lane_sel[l]];
        assign lane_bytes[l*BYTE_W +: BYTE_W] =
            lane_fwd[l] ? ent_data[lane_sel[l]][l*BYTE_W +: BYTE_W] : '0;
    end

    logic [N-1:0] wait_vec;
    always_comb begin
        wait_vec = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_wait[l]) wait_vec[lane_sel[l]] = 1'b1;
        end
    end

    logic             wait_hit, unk_hit;
    logic [IDX_W-1:0] wait_idx, unk_idx;

    sfw_age_pick #(.N(N), .IDX_W(IDX_W)) u_pick_wait (
        .cand (wait_vec), .youngest (youngest), .hit (wait_hit), .idx (wait_idx)
    );
    sfw_age_pick #(.N(N), .IDX_W(IDX_W)) u_pick_unk (
        .cand (addr_unknown), .youngest (youngest), .hit (unk_hit), .idx (unk_idx)
    );

    assign s1_fwd_mask_fast = ld_valid ? lane_fwd : '0;
    assign s1_dinv_fast     = ld_valid & wait_hit;

    stage2_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (ld_valid) begin
            st_d.fwd_mask = lane_fwd;
            st_d.fwd_data = lane_bytes;
            st_d.dinv     = wait_hit;
            st_d.dinv_idx = wait_hit ? wait_idx : '0;
            st_d.ainv     = unk_hit;
            st_d.ainv_idx = unk_hit ? unk_idx : '0;
            st_d.minv     = (va_hit != pa_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s2_fwd_mask = st_q.fwd_mask;
    assign s2_fwd_data = st_q.fwd_data;
    assign s2_dinv     = st_q.dinv;
    assign s2_dinv_idx = st_q.dinv_idx;
    assign s2_ainv     = st_q.ainv;
    assign s2_ainv_idx = st_q.ainv_idx;
    assign s2_minv     = st_q.minv;
endmodule

// File: rtl/sfw_lookup_chk.sv
module sfw_lookup_chk #(
    parameter int N    = 8,
    parameter int VA_W = 40,
    parameter int PA_W = 36,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [15:0]      ld_mask,
    input logic [15:0]      s1_fwd_mask_fast,
    input logic             s1_dinv_fast,
    input logic [15:0]      s2_fwd_mask,
    input logic [127:0]     s2_fwd_data,
    input logic             s2_dinv,
    input logic [IDX_W-1:0] s2_dinv_idx,
    input logic             s2_ainv,
    input logic [IDX_W-1:0] s2_ainv_idx,
    input logic             s2_minv
);
    a_r2_fast_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_fwd_mask_fast & ~ld_mask) == '0);

    a_r10_s1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (s1_fwd_mask_fast == '0 && !s1_dinv_fast));

    a_r10_s2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> (s2_fwd_mask == '0 && !s2_dinv && !s2_ainv && !s2_minv));

    a_r3_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> s2_fwd_mask == $past(s1_fwd_mask_fast));

    a_r6_dinv_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> s2_dinv == $past(s1_dinv_fast));

    a_r6_dinv_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_dinv |-> s2_dinv_idx == '0);

    a_r7_ainv_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_ainv |-> s2_ainv_idx == '0);

    for (genvar l = 0; l < 16; l++) begin : g_lane
        a_r3_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !s2_fwd_mask[l] |-> s2_fwd_data[l*8 +: 8] == 8'h00);
    end
endmodule

bind sfw_lookup sfw_lookup_chk #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/sim_sfw_lookup.sv
module sim_sfw_lookup;
    localparam int N     = 8;
    localparam int VA_W  = 40;
    localparam int PA_W  = 36;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             sq_wr_en = 0;
    logic [IDX_W-1:0] sq_wr_idx = '0;
    logic [VA_W-1:0]  sq_wr_va = '0;
    logic [PA_W-1:0]  sq_wr_pa = '0;
    logic [15:0]      sq_wr_mask = '0;
    logic             sq_wr_addr_ok = 0;
    logic [127:0]     sq_wr_data = '0;
    logic             sq_wr_data_ok = 0;
    logic             ld_valid = 0;
    logic [VA_W-1:0]  ld_va = '0;
    logic [PA_W-1:0]  ld_pa = '0;
    logic [15:0]      ld_mask = '0;
    logic [N-1:0]     ld_older = '0;
    logic [15:0]      s1_fwd_mask_fast, s2_fwd_mask;
    logic             s1_dinv_fast, s2_dinv, s2_ainv, s2_minv;
    logic [127:0]     s2_fwd_data;
    logic [IDX_W-1:0] s2_dinv_idx, s2_ainv_idx;

    sfw_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u0 (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Shadow of the store queue, updated after the write edge.
    logic             m_aok [N];
    logic             m_dok [N];
    logic [VA_W-1:0]  m_va [N];
    logic [PA_W-1:0]  m_pa [N];
    logic [15:0]      m_mask [N];
    logic [127:0]     m_data [N];

    logic [15:0]      e_fm;
    logic [127:0]     e_fd;
    logic             e_dv, e_av, e_mv;
    logic [IDX_W-1:0] e_dvi, e_avi;

    function automatic logic [127:0] pat(input logic [7:0] seed);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[b*8 +: 8] = seed + 8'(b);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected results from the requirements (R2..R10).
    task automatic model();
        int y;
        logic [N-1:0] dv, vh, ph, av;
        y = N - 1;
        for (int i = 0; i < N; i++)
            if (ld_older[i] && !ld_older[(i + 1) % N]) y = i;
        e_fm = '0; e_fd = '0; dv = '0; vh = '0; ph = '0; av = '0;
        for (int i = 0; i < N; i++) begin
            if (ld_older[i] && !m_aok[i]) av[i] = 1'b1;
            if (ld_older[i] && m_aok[i] && (m_mask[i] & ld_mask) != 0) begin
                if (m_va[i][VA_W-1:4] == ld_va[VA_W-1:4]) vh[i] = 1'b1;
                if (m_pa[i][PA_W-1:4] == ld_pa[PA_W-1:4]) ph[i] = 1'b1;
            end
        end
        for (int l = 0; l < 16; l++) begin
            bit found;
            int sel;
            found = 0; sel = 0;
            for (int k = 0; k < N; k++) begin
                int i;
                i = (y - k + N) % N;
                if (!found && vh[i] && m_mask[i][l] && ld_mask[l]) begin
                    found = 1; sel = i;
                end
            end
            if (found && m_dok[sel]) begin
                e_fm[l] = 1'b1;
                e_fd[l*8 +: 8] = m_data[sel][l*8 +: 8];
            end else if (found) begin
                dv[sel] = 1'b1;
            end
        end
        e_dv = 0; e_dvi = '0; e_av = 0; e_avi = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int i;
            i = (y - k + N) % N;
            if (dv[i]) begin e_dv = 1; e_dvi = IDX_W'(i); end
            if (av[i]) begin e_av = 1; e_avi = IDX_W'(i); end
        end
        e_mv = (vh != ph);
        if (!ld_valid) begin
            e_fm = '0; e_fd = '0; e_dv = 0; e_dvi = '0; e_av = 0; e_avi = '0; e_mv = 0;
        end
    endtask

    task automatic wr(input int idx, input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                      input logic [15:0] m, input logic aok, input logic [127:0] d,
                      input logic dok);
        @(negedge clk);
        sq_wr_en = 1; sq_wr_idx = IDX_W'(idx); sq_wr_va = va; sq_wr_pa = pa;
        sq_wr_mask = m; sq_wr_addr_ok = aok; sq_wr_data = d; sq_wr_data_ok = dok;
        @(negedge clk);
        sq_wr_en = 0;
        m_aok[idx] = aok; m_dok[idx] = dok; m_va[idx] = va; m_pa[idx] = pa;
        m_mask[idx] = m; m_data[idx] = d;
    endtask

    // Entries on far-away lines, all known and ready.
    task automatic init_queue();
        for (int i = 0; i < N; i++)
            wr(i, VA_W'(32'h9000 + i * 256), PA_W'(32'h5000 + i * 256), 16'hFFFF, 1,
               pat(8'(i * 16)), 1);
    endtask

    task automatic check_s1(input string tag);
        model();
        chk({tag, " s1 fast mask"}, 128'(s1_fwd_mask_fast), 128'(e_fm));
        chk({tag, " s1 fast dinv"}, 128'(s1_dinv_fast), 128'(e_dv));
    endtask

    task automatic check_s2(input string tag);
        chk({tag, " s2 mask"}, 128'(s2_fwd_mask), 128'(e_fm));
        chk({tag, " s2 data"}, s2_fwd_data, e_fd);
        chk({tag, " s2 dinv"}, 128'(s2_dinv), 128'(e_dv));
        chk({tag, " s2 dinv idx"}, 128'(s2_dinv_idx), 128'(e_dvi));
        chk({tag, " s2 ainv"}, 128'(s2_ainv), 128'(e_av));
        chk({tag, " s2 ainv idx"}, 128'(s2_ainv_idx), 128'(e_avi));
        chk({tag, " s2 minv"}, 128'(s2_minv), 128'(e_mv));
    endtask

    task automatic lookup(input string tag, input logic v, input logic [VA_W-1:0] va,
                          input logic [PA_W-1:0] pa, input logic [15:0] m,
                          input logic [N-1:0] older);
        @(negedge clk);
        ld_valid = v; ld_va = va; ld_pa = pa; ld_mask = m; ld_older = older;
        #1;
        check_s1(tag);
        @(negedge clk);
        check_s2(tag);
        ld_valid = 0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 s2 mask after reset", 128'(s2_fwd_mask), 128'd0);
        chk("R1 s2 data after reset", s2_fwd_data, 128'd0);
        chk("R1 s2 flags after reset", 128'({s2_dinv, s2_ainv, s2_minv}), 128'd0);
        for (int i = 0; i < N; i++) begin
            m_aok[i] = 0; m_dok[i] = 0; m_va[i] = '0; m_pa[i] = '0;
            m_mask[i] = '0; m_data[i] = '0;
        end
        // R1: every entry starts with an unknown address.
        lookup("R1 R7 empty queue", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_0100);
        chk("R1 ainv idx hard", 128'(s2_ainv_idx), 128'd2);
    endtask

    task automatic t_basic();
        init_queue();
        wr(2, 40'h1000, 36'h8000, 16'h00FF, 1, pat(8'hA0), 1);
        lookup("R2 R3 basic", 1, 40'h1004, 36'h8008, 16'hFFFF, 8'b0000_0111);
        chk("R3 basic mask hard", 128'(s2_fwd_mask), 128'h00FF);
        chk("R3 basic byte0 hard", 128'(s2_fwd_data[7:0]), 128'hA0);
        lookup("R2 R3 partial load", 1, 40'h100F, 36'h800F, 16'h0F3C, 8'b0000_0111);
    endtask

    task automatic t_age();
        init_queue();
        wr(3, 40'h1000, 36'h8000, 16'h0F0F, 1, pat(8'h30), 1);
        wr(5, 40'h1000, 36'h8000, 16'h00FF, 1, pat(8'h50), 1);
        lookup("R4 youngest per lane", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0011_1111);
        chk("R4 lane8 from entry3", 128'(s2_fwd_data[71:64]), 128'h38);
        lookup("R4 younger excluded", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_1111);
        init_queue();
        wr(7, 40'h1000, 36'h8000, 16'h000F, 1, pat(8'h70), 1);
        wr(1, 40'h1000, 36'h8000, 16'h000F, 1, pat(8'h10), 1);
        lookup("R4 wrap youngest", 1, 40'h1000, 36'h8000, 16'h00FF, 8'b1110_0011);
        chk("R4 wrap byte0 entry1", 128'(s2_fwd_data[7:0]), 128'h10);
        lookup("R4 all older", 1, 40'h1000, 36'h8000, 16'h00FF, 8'hFF);
        chk("R4 all ones byte0 entry7", 128'(s2_fwd_data[7:0]), 128'h70);
    endtask

    task automatic t_line();
        init_queue();
        wr(2, 40'h1010, 36'h8010, 16'hFFFF, 1, pat(8'h22), 1);
        wr(4, 40'h1000, 36'h8000, 16'hF000, 1, pat(8'h44), 1);
        lookup("R5 next line and disjoint", 1, 40'h1008, 36'h8008, 16'h0FFF, 8'b0001_1111);
        chk("R5 nothing forwarded", 128'(s2_fwd_mask), 128'd0);
        lookup("R5 offset ignored", 1, 40'h100C, 36'h800C, 16'hF000, 8'b0001_1111);
    endtask

    task automatic t_dinv();
        init_queue();
        wr(2, 40'h1000, 36'h8000, 16'h00FF, 1, pat(8'h20), 0);
        wr(4, 40'h1000, 36'h8000, 16'h00FF, 1, pat(8'h40), 1);
        lookup("R6 hidden by younger", 1, 40'h1000, 36'h8000, 16'h00FF, 8'b0001_1111);
        lookup("R6 waiting store", 1, 40'h1000, 36'h8000, 16'h00FF, 8'b0000_0111);
        chk("R6 dinv idx hard", 128'(s2_dinv_idx), 128'd2);
        wr(4, 40'h1000, 36'h8000, 16'h000F, 1, pat(8'h40), 1);
        lookup("R6 partial cover", 1, 40'h1000, 36'h8000, 16'h00FF, 8'b0001_1111);
    endtask

    task automatic t_ainv();
        init_queue();
        wr(6, 40'h1000, 36'h8000, 16'hFFFF, 0, pat(8'h60), 1);
        wr(3, 40'h3000, 36'h3000, 16'hFFFF, 0, pat(8'h60), 1);
        lookup("R7 youngest unknown", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0111_1111);
        chk("R7 ainv idx hard", 128'(s2_ainv_idx), 128'd6);
        lookup("R7 older unknown", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_1111);
    endtask

    task automatic t_minv();
        init_queue();
        wr(1, 40'h1000, 36'h7700, 16'h00FF, 1, pat(8'h11), 1);
        lookup("R8 va only hit", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_0011);
        chk("R8 minv hard", 128'(s2_minv), 128'd1);
        init_queue();
        wr(1, 40'h3000, 36'h8000, 16'h00FF, 1, pat(8'h11), 1);
        lookup("R8 pa only hit", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_0011);
    endtask

    task automatic t_outside();
        init_queue();
        wr(5, 40'h1000, 36'h7000, 16'hFFFF, 0, pat(8'h55), 0);
        lookup("R9 entry not older", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_1111);
        chk("R9 no flags", 128'({s2_dinv, s2_ainv, s2_minv}), 128'd0);
    endtask

    task automatic t_idle();
        init_queue();
        wr(2, 40'h1000, 36'h9999, 16'hFFFF, 1, pat(8'h20), 0);
        wr(1, 40'h1000, 36'h8000, 16'hFFFF, 0, pat(8'h20), 0);
        lookup("R10 valid low", 0, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_0111);
        chk("R10 quiet s2", 128'({s2_fwd_mask, s2_dinv, s2_ainv, s2_minv}), 128'd0);
    endtask

    task automatic t_same_cycle();
        init_queue();
        wr(2, 40'h1000, 36'h8000, 16'hFFFF, 1, pat(8'h20), 1);
        @(negedge clk);
        sq_wr_en = 1; sq_wr_idx = 2; sq_wr_va = 40'h1000; sq_wr_pa = 36'h8000;
        sq_wr_mask = 16'hFFFF; sq_wr_addr_ok = 1; sq_wr_data = pat(8'h40); sq_wr_data_ok = 1;
        ld_valid = 1; ld_va = 40'h1000; ld_pa = 36'h8000; ld_mask = 16'hFFFF;
        ld_older = 8'b0000_0111;
        #1;
        check_s1("R11 same cycle");
        @(negedge clk);
        check_s2("R11 same cycle old data");
        chk("R11 old byte0 hard", 128'(s2_fwd_data[7:0]), 128'h20);
        sq_wr_en = 0; ld_valid = 0;
        m_data[2] = pat(8'h40);
        lookup("R11 next cycle new data", 1, 40'h1000, 36'h8000, 16'hFFFF, 8'b0000_0111);
        chk("R11 new byte0 hard", 128'(s2_fwd_data[7:0]), 128'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_age();
        t_line();
        t_dinv();
        t_ainv();
        t_minv();
        t_outside();
        t_idle();
        t_same_cycle();
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule